// File: doc/BRIEF.md
# SPI Host Interrupt and Error Aggregator

This block gathers the error and event conditions of an SPI host controller and reduces them to two level-sensitive interrupt lines: one for errors and one for events. Error conditions arrive as single-cycle pulses and are captured in a sticky status register. Event conditions arrive as level flags (host ready, transmit queue empty, receive queue full). Software clears the sticky error status by writing ones to it.

Each interrupt line has a pending bit, an enable bit and a test bit. The pending bit latches only while the line is enabled and not already pending. It latches when a test write asks for it or when a cause passes its own mask. Software clears a pending bit by writing a one to it. Each line output is its pending bit gated by its enable bit. All registers sit behind a word-indexed write port and a combinational read port.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset both interrupt outputs are 0, and every register reads 0 except the error cause mask (index 3), which reads 0x1F.
- R2: A pulse on error input bit i (0 command-while-busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip select, 5 invalid access) sets status bit i at index 4 on the next edge. The bit stays set until a write to index 4 has a 1 in bit i. Zero bits in that write have no effect.
- R3: When an error pulse and a write-1-to-clear of the same status bit arrive in the same cycle, the bit stays set.
- R4: The error pending bit (index 0, bit 0) sets one edge after a status bit in 4..0 is set, provided that bit is 1 in the cause mask (index 3, bits 4..0) and the error line is enabled (index 1, bit 0). A masked cause never sets it, and status bit 5 never sets it.
- R5: The event pending bit (index 0, bit 1) sets on the edge where an enabled condition is true: host ready with event-mask bit 4, transmit empty with bit 1, receive full with bit 0 (event mask at index 5). Event-mask bits 2, 3 and 5 have no effect.
- R6: A pending bit never latches while its line enable (index 1) is 0. Once the enable is set and a cause is still present, it latches on the following edge.
- R7: Writing 1 to a pending bit clears it on that edge. If its cause persists, the bit sets again on the next edge.
- R8: A write to index 2 sets the pending bit of each enabled line whose bit (0 error, 1 event) is 1, with or without a cause. A line that is disabled is not affected. Index 2 always reads 0.
- R9: Each interrupt output equals its pending bit ANDed with its enable bit. Clearing an enable drops the output but keeps the pending bit.
- R10: Indices 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write word index |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read word index |
| rd_data_o | output | DATA_W | Combinational read data |
| err_pulse_i | input | 6 | Single-cycle error cause pulses |
| ready_i | input | 1 | Host ready for a new command (level) |
| tx_empty_i | input | 1 | Transmit queue empty (level) |
| rx_full_i | input | 1 | Receive queue full (level) |
| irq_err_o | output | 1 | Error interrupt line |
| irq_evt_o | output | 1 | Event interrupt line |

## Verification
A wrong pending or status bit shows up at the interrupt pins within two edges of the fault: one edge for event flags and test writes, two for error pulses because they pass through the status register first. A status bit that is lost, or a clear that overrides a new error, shows directly in the read port on the next cycle. A pending bit that latches while its line is disabled stays hidden at the pins until the enable is set. The bench therefore reads the pending register at random cycles and compares it against its own cycle model. The same-edge races get directed sequences whose reads are placed on the exact cycle the requirement names: clear against pulse, clear against a persisting cause, and enable against an existing cause.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int IRQ_LINES    = 2;
  localparam int IRQ_ERR      = 0;
  localparam int IRQ_EVT      = 1;
  localparam int NUM_ERR      = 6;
  localparam int NUM_ERR_MASK = 5;
  localparam int NUM_EVT_EN   = 6;

  localparam int EVT_RXFULL  = 0;
  localparam int EVT_TXEMPTY = 1;
  localparam int EVT_READY   = 4;

  localparam logic [NUM_ERR_MASK-1:0] ERR_MASK_RESET = '1;

  typedef enum logic [2:0] {
    IDX_PENDING = 3'd0,
    IDX_LINE_EN = 3'd1,
    IDX_TEST    = 3'd2,
    IDX_ERR_MSK = 3'd3,
    IDX_ERR_STS = 3'd4,
    IDX_EVT_MSK = 3'd5
  } reg_idx_e;

  // Any unmasked error cause currently recorded in the sticky status.
  function automatic logic err_cause_f(
    input logic [NUM_ERR-1:0]      sts,
    input logic [NUM_ERR_MASK-1:0] msk
  );
    return |(sts[NUM_ERR_MASK-1:0] & msk);
  endfunction

  // Any enabled level condition true in this cycle.
  function automatic logic evt_cause_f(
    input logic [NUM_EVT_EN-1:0] msk,
    input logic                  ready,
    input logic                  tx_empty,
    input logic                  rx_full
  );
    return (msk[EVT_READY] & ready) |
           (msk[EVT_TXEMPTY] & tx_empty) |
           (msk[EVT_RXFULL] & rx_full);
  endfunction

  // Latch condition for one pending bit.
  function automatic logic fire_f(
    input logic line_en,
    input logic pending,
    input logic test,
    input logic cause
  );
    return line_en & ~pending & (test | cause);
  endfunction

  // Write-1-to-clear update in which a new set wins over a clear.
  function automatic logic [7:0] w1c_next_f(
    input logic [7:0] cur,
    input logic [7:0] set,
    input logic [7:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/spi_irq_w1c.sv
module spi_irq_w1c #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  import spi_irq_pkg::*;

  localparam int PAD = 8 - WIDTH;

  logic [7:0] nxt;

  always_comb begin
    nxt = w1c_next_f({{PAD{1'b0}}, q_o}, {{PAD{1'b0}}, set_i}, {{PAD{1'b0}}, clr_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt[WIDTH-1:0];
  end

endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    wr_addr_i,
  input  logic [DATA_W-1:0]                    wr_data_i,
  output logic [spi_irq_pkg::IRQ_LINES-1:0]    line_en_o,
  output logic [spi_irq_pkg::NUM_ERR_MASK-1:0] err_msk_o,
  output logic [spi_irq_pkg::NUM_EVT_EN-1:0]   evt_msk_o,
  output logic [spi_irq_pkg::IRQ_LINES-1:0]    test_pulse_o,
  output logic [spi_irq_pkg::IRQ_LINES-1:0]    pend_clr_o,
  output logic [spi_irq_pkg::NUM_ERR-1:0]      sts_clr_o
);
  import spi_irq_pkg::*;

  logic sel_pending, sel_line_en, sel_test, sel_err_msk, sel_err_sts, sel_evt_msk;

  always_comb begin
    sel_pending = wr_en_i && (wr_addr_i == ADDR_W'(IDX_PENDING));
    sel_line_en = wr_en_i && (wr_addr_i == ADDR_W'(IDX_LINE_EN));
    sel_test    = wr_en_i && (wr_addr_i == ADDR_W'(IDX_TEST));
    sel_err_msk = wr_en_i && (wr_addr_i == ADDR_W'(IDX_ERR_MSK));
    sel_err_sts = wr_en_i && (wr_addr_i == ADDR_W'(IDX_ERR_STS));
    sel_evt_msk = wr_en_i && (wr_addr_i == ADDR_W'(IDX_EVT_MSK));
  end

  // Strobes that act for one cycle only and are never stored.
  assign test_pulse_o = sel_test    ? wr_data_i[IRQ_LINES-1:0] : '0;
  assign pend_clr_o   = sel_pending ? wr_data_i[IRQ_LINES-1:0] : '0;
  assign sts_clr_o    = sel_err_sts ? wr_data_i[NUM_ERR-1:0]   : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_en_o <= '0;
      err_msk_o <= ERR_MASK_RESET;
      evt_msk_o <= '0;
    end else begin
      if (sel_line_en) line_en_o <= wr_data_i[IRQ_LINES-1:0];
      if (sel_err_msk) err_msk_o <= wr_data_i[NUM_ERR_MASK-1:0];
      if (sel_evt_msk) evt_msk_o <= wr_data_i[NUM_EVT_EN-1:0];
    end
  end

endmodule

// File: rtl/spi_irq_cause.sv
module spi_irq_cause (
  input  logic [spi_irq_pkg::IRQ_LINES-1:0]    line_en_i,
  input  logic [spi_irq_pkg::IRQ_LINES-1:0]    pending_i,
  input  logic [spi_irq_pkg::IRQ_LINES-1:0]    test_i,
  input  logic [spi_irq_pkg::NUM_ERR-1:0]      err_sts_i,
  input  logic [spi_irq_pkg::NUM_ERR_MASK-1:0] err_msk_i,
  input  logic [spi_irq_pkg::NUM_EVT_EN-1:0]   evt_msk_i,
  input  logic                                 ready_i,
  input  logic                                 tx_empty_i,
  input  logic                                 rx_full_i,
  output logic [spi_irq_pkg::IRQ_LINES-1:0]    fire_o
);
  import spi_irq_pkg::*;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
    logic line_cause;
    if (g == IRQ_ERR) begin : g_err
      assign line_cause = err_cause_f(err_sts_i, err_msk_i);
    end else begin : g_evt
      assign line_cause = evt_cause_f(evt_msk_i, ready_i, tx_empty_i, rx_full_i);
    end
    assign fire_o[g] = fire_f(line_en_i[g], pending_i[g], test_i[g], line_cause);
  end

endmodule

// File: rtl/spi_irq_rdmux.sv
module spi_irq_rdmux #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]                    rd_addr_i,
  input  logic [spi_irq_pkg::IRQ_LINES-1:0]    pending_i,
  input  logic [spi_irq_pkg::IRQ_LINES-1:0]    line_en_i,
  input  logic [spi_irq_pkg::NUM_ERR_MASK-1:0] err_msk_i,
  input  logic [spi_irq_pkg::NUM_ERR-1:0]      err_sts_i,
  input  logic [spi_irq_pkg::NUM_EVT_EN-1:0]   evt_msk_i,
  output logic [DATA_W-1:0]                    rd_data_o
);
  import spi_irq_pkg::*;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(IDX_PENDING): rd_data_o = DATA_W'(pending_i);
      ADDR_W'(IDX_LINE_EN): rd_data_o = DATA_W'(line_en_i);
      ADDR_W'(IDX_ERR_MSK): rd_data_o = DATA_W'(err_msk_i);
      ADDR_W'(IDX_ERR_STS): rd_data_o = DATA_W'(err_sts_i);
      ADDR_W'(IDX_EVT_MSK): rd_data_o = DATA_W'(evt_msk_i);
      default:              rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic [ADDR_W-1:0]                rd_addr_i,
  output logic [DATA_W-1:0]                rd_data_o,
  input  logic [spi_irq_pkg::NUM_ERR-1:0]  err_pulse_i,
  input  logic                             ready_i,
  input  logic                             tx_empty_i,
  input  logic                             rx_full_i,
  output logic                             irq_err_o,
  output logic                             irq_evt_o
);
  import spi_irq_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [IRQ_LINES-1:0]    line_en;
  logic [NUM_ERR_MASK-1:0] err_msk;
  logic [NUM_EVT_EN-1:0]   evt_msk;
  logic [IRQ_LINES-1:0]    test_pulse;
  logic [IRQ_LINES-1:0]    pend_clr;
  logic [NUM_ERR-1:0]      sts_clr;
  logic [NUM_ERR-1:0]      err_sts;
  logic [IRQ_LINES-1:0]    pending;
  logic [IRQ_LINES-1:0]    fire;

  spi_irq_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .line_en_o    (line_en),
    .err_msk_o    (err_msk),
    .evt_msk_o    (evt_msk),
    .test_pulse_o (test_pulse),
    .pend_clr_o   (pend_clr),
    .sts_clr_o    (sts_clr)
  );

  spi_irq_w1c #(.WIDTH(NUM_ERR)) u_err_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_pulse_i),
    .clr_i  (sts_clr),
    .q_o    (err_sts)
  );

  spi_irq_cause u_cause (
    .line_en_i  (line_en),
    .pending_i  (pending),
    .test_i     (test_pulse),
    .err_sts_i  (err_sts),
    .err_msk_i  (err_msk),
    .evt_msk_i  (evt_msk),
    .ready_i    (ready_i),
    .tx_empty_i (tx_empty_i),
    .rx_full_i  (rx_full_i),
    .fire_o     (fire)
  );

  spi_irq_w1c #(.WIDTH(IRQ_LINES)) u_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fire),
    .clr_i  (pend_clr),
    .q_o    (pending)
  );

  spi_irq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .rd_addr_i (rd_addr_i),
    .pending_i (pending),
    .line_en_i (line_en),
    .err_msk_i (err_msk),
    .err_sts_i (err_sts),
    .evt_msk_i (evt_msk),
    .rd_data_o (rd_data_o)
  );

  assign irq_err_o = pending[IRQ_ERR] & line_en[IRQ_ERR];
  assign irq_evt_o = pending[IRQ_EVT] & line_en[IRQ_EVT];

endmodule

// File: rtl/spi_irq_agg_chk.sv
module spi_irq_agg_chk (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic [spi_irq_pkg::IRQ_LINES-1:0]    line_en,
  input logic [spi_irq_pkg::IRQ_LINES-1:0]    pending,
  input logic [spi_irq_pkg::IRQ_LINES-1:0]    fire,
  input logic [spi_irq_pkg::IRQ_LINES-1:0]    test_pulse,
  input logic [spi_irq_pkg::NUM_ERR-1:0]      err_sts,
  input logic [spi_irq_pkg::NUM_ERR-1:0]      sts_clr,
  input logic [spi_irq_pkg::NUM_ERR-1:0]      err_pulse,
  input logic                                 irq_err,
  input logic                                 irq_evt
);

  // R2: a status bit only falls when software wrote a 1 to it
  a_r2_sticky_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(err_sts) & ~$past(sts_clr) & ~err_sts) == '0));

  // R3: every pulse is recorded, even against a same-cycle clear
  a_r3_pulse_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_pulse != '0) |=> ((err_sts & $past(err_pulse)) == $past(err_pulse)));

  // R4: the error pending bit rises only after a latch condition
  a_r4_err_rise_caused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending[0]) |-> $past(fire[0]));

  // R6: no latch while a line is disabled
  a_r6_err_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_en[0] && !pending[0]) |=> !pending[0]);
  a_r6_evt_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_en[1] && !pending[1]) |=> !pending[1]);

  // R8: a test write on an enabled line leaves it pending
  a_r8_test_sets_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_pulse[1] && line_en[1]) |=> pending[1]);

  // R9: a disabled line keeps its output low
  a_r9_err_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en[0] |-> !irq_err);
  a_r9_evt_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en[1] |-> !irq_evt);

endmodule

bind spi_irq_agg spi_irq_agg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_en    (line_en),
  .pending    (pending),
  .fire       (fire),
  .test_pulse (test_pulse),
  .err_sts    (err_sts),
  .sts_clr    (sts_clr),
  .err_pulse  (err_pulse_i),
  .irq_err    (irq_err_o),
  .irq_evt    (irq_evt_o)
);

// File: tb/spi_irq_agg_tb_top.sv
module spi_irq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  err_pulse = '0;
  logic        ready = 1'b0, tx_empty = 1'b0, rx_full = 1'b0;
  logic        irq_err, irq_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_irq_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .err_pulse_i(err_pulse), .ready_i(ready), .tx_empty_i(tx_empty),
    .rx_full_i(rx_full), .irq_err_o(irq_err), .irq_evt_o(irq_evt)
  );

  // Cycle model built from the requirements.
  logic [1:0] m_pend, m_en;
  logic [4:0] m_emsk;
  logic [5:0] m_sts, m_vmsk;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_pend};
      3'd1: return {30'd0, m_en};
      3'd3: return {27'd0, m_emsk};
      3'd4: return {26'd0, m_sts};
      3'd5: return {26'd0, m_vmsk};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_emsk = 5'h1F; m_sts = '0; m_vmsk = '0;
    end else begin
      logic [1:0] t, c, f;
      logic ec, vc;
      t  = (wr_en && wr_addr == 3'd2) ? wr_data[1:0] : 2'b00;
      c  = (wr_en && wr_addr == 3'd0) ? wr_data[1:0] : 2'b00;
      ec = (m_sts[4:0] & m_emsk) != 0;
      vc = (m_vmsk[4] && ready) || (m_vmsk[1] && tx_empty) || (m_vmsk[0] && rx_full);
      f[0] = m_en[0] && !m_pend[0] && (t[0] || ec);
      f[1] = m_en[1] && !m_pend[1] && (t[1] || vc);
      m_pend = (m_pend & ~c) | f;
      m_sts  = (m_sts & ~((wr_en && wr_addr == 3'd4) ? wr_data[5:0] : 6'd0)) | err_pulse;
      if (wr_en && wr_addr == 3'd1) m_en   = wr_data[1:0];
      if (wr_en && wr_addr == 3'd3) m_emsk = wr_data[4:0];
      if (wr_en && wr_addr == 3'd5) m_vmsk = wr_data[5:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    err_pulse = p;
    @(negedge clk);
    err_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = 32'h5A17_C3E1;
    void'($urandom(seed_v));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 unused indices
    chk("R1 irq lines", {30'd0, irq_evt, irq_err}, 32'd0);
    rd_chk("R1 pending", 3'd0, 32'd0);
    rd_chk("R1 line enable", 3'd1, 32'd0);
    rd_chk("R1 test", 3'd2, 32'd0);
    rd_chk("R1 err mask", 3'd3, 32'h1F);
    rd_chk("R1 err status", 3'd4, 32'd0);
    rd_chk("R1 evt mask", 3'd5, 32'd0);
    rd_chk("R10 index 6", 3'd6, 32'd0);
    rd_chk("R10 index 7", 3'd7, 32'd0);

    // R2 sticky status and selective clear
    pulse(6'b100101);
    rd_chk("R2 capture", 3'd4, 32'h25);
    wr(3'd4, 32'h04);
    rd_chk("R2 clear one bit", 3'd4, 32'h21);
    wr(3'd4, 32'h00);
    rd_chk("R2 zero write", 3'd4, 32'h21);
    wr(3'd4, 32'h3F);
    rd_chk("R2 clear all", 3'd4, 32'h00);

    // R3 pulse against same-cycle clear
    @(negedge clk);
    err_pulse = 6'b000010; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h02;
    @(negedge clk);
    err_pulse = '0; wr_en = 1'b0;
    rd_chk("R3 new error wins", 3'd4, 32'h02);
    wr(3'd4, 32'h3F);

    // R4 masking and latency
    wr(3'd1, 32'h1);
    pulse(6'b100000);
    idle(3);
    rd_chk("R4 bit5 never fires", 3'd0, 32'd0);
    wr(3'd4, 32'h3F);
    wr(3'd3, 32'h1E);
    pulse(6'b000001);
    idle(3);
    rd_chk("R4 masked cause", 3'd0, 32'd0);
    pulse(6'b001000);
    chk("R4 not yet pending", {31'd0, irq_err}, 32'd0);
    @(negedge clk);
    chk("R4 pending one edge later", {31'd0, irq_err}, 32'd1);
    wr(3'd4, 32'h3F);
    wr(3'd0, 32'h1);
    wr(3'd3, 32'h1F);
    rd_chk("R4 cleared", 3'd0, 32'd0);

    // R7 clear with persisting cause
    pulse(6'b010000);
    @(negedge clk);
    rd_chk("R7 set", 3'd0, 32'd1);
    wr(3'd0, 32'h1);
    rd_chk("R7 cleared on edge", 3'd0, 32'd0);
    @(negedge clk);
    rd_chk("R7 re-set by cause", 3'd0, 32'd1);
    wr(3'd4, 32'h3F);
    wr(3'd0, 32'h1);
    @(negedge clk);
    rd_chk("R7 stays clear", 3'd0, 32'd0);

    // R5 event causes
    wr(3'd1, 32'h2);
    wr(3'd5, 32'h2C);
    ready = 1'b1; tx_empty = 1'b1; rx_full = 1'b1;
    idle(3);
    rd_chk("R5 unused mask bits", 3'd0, 32'd0);
    ready = 1'b0; tx_empty = 1'b0; rx_full = 1'b0;
    for (int c = 0; c < 3; c++) begin
      wr(3'd5, (c == 0) ? 32'h10 : (c == 1) ? 32'h02 : 32'h01);
      if (c == 0) ready = 1'b1; else if (c == 1) tx_empty = 1'b1; else rx_full = 1'b1;
      chk("R5 before edge", {31'd0, irq_evt}, 32'd0);
      @(negedge clk);
      chk("R5 event fires", {31'd0, irq_evt}, 32'd1);
      ready = 1'b0; tx_empty = 1'b0; rx_full = 1'b0;
      wr(3'd0, 32'h2);
      @(negedge clk);
      rd_chk("R5 cleared", 3'd0, 32'd0);
    end

    // R6 no latch while disabled, latch once enabled; R9 gating
    wr(3'd1, 32'h0);
    wr(3'd5, 32'h13);
    ready = 1'b1;
    pulse(6'b000001);
    idle(3);
    rd_chk("R6 disabled no latch", 3'd0, 32'd0);
    wr(3'd1, 32'h3);
    rd_chk("R6 enable edge", 3'd0, 32'd0);
    @(negedge clk);
    rd_chk("R6 latched after enable", 3'd0, 32'd3);
    chk("R9 both lines high", {30'd0, irq_evt, irq_err}, 32'd3);
    wr(3'd1, 32'h0);
    chk("R9 lines gated", {30'd0, irq_evt, irq_err}, 32'd0);
    rd_chk("R9 pending kept", 3'd0, 32'd3);
    ready = 1'b0;
    wr(3'd4, 32'h3F);
    wr(3'd0, 32'h3);
    rd_chk("R6 cleanup", 3'd0, 32'd0);

    // R8 test writes
    wr(3'd1, 32'h3);
    wr(3'd2, 32'h2);
    rd_chk("R8 event only", 3'd0, 32'd2);
    wr(3'd2, 32'h1);
    rd_chk("R8 both", 3'd0, 32'd3);
    chk("R8 lines", {30'd0, irq_evt, irq_err}, 32'd3);
    rd_chk("R8 test reads zero", 3'd2, 32'd0);
    wr(3'd0, 32'h3);
    @(negedge clk);
    rd_chk("R8 no cause after clear", 3'd0, 32'd0);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h3);
    rd_chk("R8 disabled line", 3'd0, 32'd0);

    // R10 writes to unused indices
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd_chk("R10 enable untouched", 3'd1, 32'd0);
    rd_chk("R10 mask untouched", 3'd3, 32'h1F);
    rd_chk("R10 status untouched", 3'd4, 32'd0);
    rd_chk("R10 evt mask untouched", 3'd5, 32'h13);

    // Random phase against the model
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R9 random lines", {30'd0, irq_evt, irq_err}, {30'd0, m_pend & m_en});
      rd_addr = 3'($urandom % 8);
      #1;
      chk("R10 random read", rd_data, model_read(rd_addr));
      wr_en     = ($urandom % 4) == 0;
      wr_addr   = 3'($urandom % 8);
      wr_data   = $urandom;
      err_pulse = (($urandom % 6) == 0) ? 6'($urandom) : 6'd0;
      if (($urandom % 5) == 0) ready    = $urandom % 2;
      if (($urandom % 5) == 0) tx_empty = $urandom % 2;
      if (($urandom % 5) == 0) rx_full  = $urandom % 2;
    end
    wr_en = 1'b0; err_pulse = '0;
    idle(2);
    finish_run();
  end

endmodule